// File: doc/BRIEF.md
# UART Receive/Transmit Line Status Tracker

This block holds the line status of a UART and presents it as an 8-bit read-only status word. Characters arrive already deserialized, each with three error flags. They go into a small receive queue that stores the flags next to the data. A software or DMA consumer takes characters out with a pop strobe. The error flags of a character are reported only when that character reaches the head of the queue. The block also keeps an aggregate "some stored character is bad" bit, and that bit gates the receive DMA request. Two occupancy inputs from the transmit side are reduced to the two transmit status bits.

The receive input is a stream with a valid strobe and no ready. Every character offered is consumed in its cycle, so there is no back-pressure. A character that arrives while the receive store is full is dropped and recorded as an overrun. The head character is always visible on `rd_data`, and it is taken by `rx_pop` while data ready is 1. A pop on an empty store has no effect.

In queue mode the store holds `DEPTH` characters. In single mode it holds one character. The mode should be changed only while the store is empty.

Top module: `uart_lsr_tracker`

## Requirements
- R1: The status word is {queue error, transmitter empty, transmit request, break, framing, parity, overrun, data ready}, with bit 7 first. After reset it reads 8'h60, and `ls_irq`, `err_irq` and `dma_req` are 0.
- R2: Bit 0 is 1 exactly when the receive store holds at least one character, and `rd_data` shows the oldest stored character. A push or pop takes effect at the next clock edge.
- R3: The `rx_err` encoding is bit 2 break, bit 1 framing and bit 0 parity. In queue mode, the flags of a stored character are OR-ed into status bits 4:2 (break, framing, parity) at the edge where that character becomes the head: when it is pushed into an empty store, or when the character ahead of it is popped. They are not OR-ed in when the character is pushed behind others.
- R4: In single mode the store holds one character, and a character's flags are OR-ed into bits 4:2 at the edge where it is accepted.
- R5: Bits 4:1 are sticky. A status read (`status_rd`) clears them at the next edge, except for any bit that a detection in the same cycle sets, which stays 1.
- R6: A character offered while the store is full (64 entries in queue mode, one in single mode) is discarded. It sets bit 1, and the stored data does not change. Fullness is judged before any pop in the same cycle.
- R7: Bit 7 is 1 in queue mode while any stored character has a nonzero flag. It is not cleared by a status read, it clears once the last such character is popped, and it is always 0 in single mode.
- R8: `ls_irq` is `ls_irq_en` AND (any of bits 4:1).
- R9: `err_irq` is `dma_en` AND bit 7, so bit 7 raises no interrupt while `dma_en` is 0.
- R10: `dma_req` is 1 when `dma_en` is 1, bit 7 is 0, and the fill level is at least `TRIG` in queue mode or at least 1 in single mode. It is suppressed while bit 7 is 1 and resumes by itself once bit 7 clears.
- R11: Bit 6 equals `tx_hold_empty` AND `tx_shift_empty`, and bit 5 equals `tx_hold_empty`. Each is registered once, so it follows its inputs from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 selects queue mode, 0 selects single mode |
| dma_en | input | 1 | Receive DMA enable |
| ls_irq_en | input | 1 | Line-status interrupt enable |
| rx_valid | input | 1 | A received character is offered this cycle |
| rx_data | input | 8 | Received character |
| rx_err | input | 3 | Flags of the offered character: {break, framing, parity} |
| rx_pop | input | 1 | Remove the head character |
| status_rd | input | 1 | Status word read strobe |
| tx_hold_empty | input | 1 | Transmit holding register or transmit queue is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| status | output | 8 | Line status word |
| rd_data | output | 8 | Head character of the receive store |
| ls_irq | output | 1 | Receiver line-status interrupt |
| err_irq | output | 1 | Queue error interrupt |
| dma_req | output | 1 | Receive DMA request |

## Verification
The hardest situation to reach is an erroneous character that sits deep in a full 64-entry queue behind good characters. That character must stay silent in bits 4:2 until everything ahead of it has been popped. Meanwhile bit 7 must stay up across status reads and keep the DMA request blocked. The stimulus fills the queue with a scripted pattern that places bad characters in the middle and at the end, and it overruns the full queue in the same cycle as a status read. It then drains the queue one pop at a time, with reads in between. A long random phase in both modes follows, and a behavioural queue model checks every cycle.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_err_t;

  typedef struct packed {
    rx_err_t           err;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/lsr_rx_fifo.sv
module lsr_rx_fifo
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  rx_entry_t                    wdata,
  input  logic                         pop,
  output rx_entry_t                    head,
  output rx_err_t                      next_err,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wptr, rptr, rptr_nx;
  logic [CW-1:0]   cnt_q;

  assign rptr_nx  = (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
  assign head     = mem[rptr];
  assign next_err = mem[rptr_nx].err;
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= rptr_nx;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |-> cnt_q < CW'(DEPTH));
  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
endmodule

// File: rtl/lsr_err_count.sv
module lsr_err_count #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          any
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (inc && !dec) cnt <= cnt + 1'b1;
    else if (dec && !inc) cnt <= cnt - 1'b1;
  end

  assign any = (cnt != '0);

  // R7
  err_cnt_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec && !inc |-> cnt != '0);
endmodule

// File: rtl/lsr_sticky_bits.sv
module lsr_sticky_bits #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[i] <= 1'b0;
      else if (set[i])  q[i] <= 1'b1;
      else if (clr)     q[i] <= 1'b0;
    end
  end

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && set == '0 |=> q == '0);
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && set != '0 |=> (q & $past(set)) == $past(set));
endmodule

// File: rtl/uart_lsr_tracker.sv
module uart_lsr_tracker
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TRIG  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       dma_en,
  input  logic       ls_irq_en,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic [2:0] rx_err,
  input  logic       rx_pop,
  input  logic       status_rd,
  input  logic       tx_hold_empty,
  input  logic       tx_shift_empty,
  output logic [7:0] status,
  output logic [7:0] rd_data,
  output logic       ls_irq,
  output logic       err_irq,
  output logic       dma_req
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] TRIG_C  = CW'(TRIG);

  rx_entry_t       wentry, head;
  rx_err_t         next_err, arr_err;
  logic [CW-1:0]   count, cap, after, err_cnt;
  logic            full, push_ok, pop_ok, ovr, arrive, err_any, q_err;
  logic [3:0]      sticky, sticky_set;
  logic            temt_q, thre_q;

  assign cap     = fifo_mode ? DEPTH_C : CW'(1);
  assign full    = count >= cap;
  assign push_ok = rx_valid && !full;
  assign ovr     = rx_valid && full;
  assign pop_ok  = rx_pop && (count != '0);
  assign after   = count + CW'(push_ok) - CW'(pop_ok);
  assign wentry  = '{err: rx_err_t'(rx_err), data: rx_data};

  // A new character becomes the head this edge
  assign arrive  = (pop_ok || count == '0) && (after != '0);
  assign arr_err = (pop_ok && count > CW'(1)) ? next_err : rx_err_t'(rx_err);

  lsr_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_ok),
    .wdata    (wentry),
    .pop      (pop_ok),
    .head     (head),
    .next_err (next_err),
    .count    (count)
  );

  lsr_err_count #(.CW(CW)) u_errs (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (push_ok && (rx_err != 3'b000)),
    .dec   (pop_ok && (head.err != '0)),
    .cnt   (err_cnt),
    .any   (err_any)
  );

  assign sticky_set = {arrive ? arr_err : 3'b000, ovr};

  lsr_sticky_bits #(.N(4)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (sticky_set),
    .clr   (status_rd),
    .q     (sticky)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temt_q <= 1'b1;
      thre_q <= 1'b1;
    end else begin
      temt_q <= tx_hold_empty && tx_shift_empty;
      thre_q <= tx_hold_empty;
    end
  end

  assign q_err   = fifo_mode && err_any;
  assign status  = {q_err, temt_q, thre_q, sticky, count != '0};
  assign rd_data = head.data;
  assign ls_irq  = ls_irq_en && (sticky != '0);
  assign err_irq = dma_en && q_err;
  assign dma_req = dma_en && !q_err &&
                   (fifo_mode ? (count >= TRIG_C) : (count != '0));

  // R7
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= count);
  // R7
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd && status[7] && !rx_pop && fifo_mode |=> status[7] || !fifo_mode);
  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> status[1]);
  // R6
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !rx_pop |=> $stable(count));
  // R10
  dma_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> !dma_req);
  // R2
  dr_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> status[0]);
endmodule

// File: tb/uart_lsr_tracker_test.sv
module uart_lsr_tracker_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int TRIG   = 8;

  logic clk = 0, rst_n = 0;
  logic fifo_mode = 1, dma_en = 0, ls_irq_en = 0;
  logic rx_valid = 0, rx_pop = 0, status_rd = 0;
  logic [7:0] rx_data = 0;
  logic [2:0] rx_err = 0;
  logic tx_hold_empty = 1, tx_shift_empty = 1;
  logic [7:0] status, rd_data;
  logic ls_irq, err_irq, dma_req;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // reference state
  logic [10:0] q[$];
  bit [3:0] stk;   // {brk, ferr, perr, ovr}
  bit temt_m, thre_m;

  always #(PERIOD/2) clk = ~clk;

  uart_lsr_tracker #(.DEPTH(DEPTH), .TRIG(TRIG)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .dma_en(dma_en),
    .ls_irq_en(ls_irq_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_err(rx_err), .rx_pop(rx_pop), .status_rd(status_rd),
    .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
    .status(status), .rd_data(rd_data), .ls_irq(ls_irq),
    .err_irq(err_irq), .dma_req(dma_req));

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic int errs_in_q();
    int n = 0;
    foreach (q[i]) if (q[i][10:8] != 0) n++;
    return n;
  endfunction

  task automatic model_step();
    int  cap  = fifo_mode ? DEPTH : 1;
    int  old  = q.size();
    bit  ovr  = rx_valid && (old >= cap);
    bit  popd = rx_pop && (old > 0);
    bit  arr;
    bit [3:0] set;
    if (popd) void'(q.pop_front());
    if (rx_valid && !ovr) q.push_back({rx_err, rx_data});
    arr = (popd || old == 0) && q.size() > 0;
    set = {arr ? q[0][10:8] : 3'b000, ovr};
    stk = status_rd ? set : (stk | set);
    temt_m = tx_hold_empty && tx_shift_empty;
    thre_m = tx_hold_empty;
  endtask

  task automatic compare_all();
    bit qe = fifo_mode && errs_in_q() > 0;
    string st = fifo_mode ? "R3 R5" : "R4 R5";
    chk("R2 data ready", status[0], q.size() > 0);
    if (q.size() > 0) chk("R2 head data", rd_data, q[0][7:0]);
    chk("R6 overrun", status[1], stk[0]);
    chk(st, status[4:2], stk[3:1]);
    chk("R7 queue error", status[7], qe);
    chk("R11 tx bits", status[6:5], {temt_m, thre_m});
    chk("R8 ls_irq", ls_irq, ls_irq_en && stk != 0);
    chk("R9 err_irq", err_irq, dma_en && qe);
    chk("R10 dma_req", dma_req,
        dma_en && !qe && (fifo_mode ? q.size() >= TRIG : q.size() > 0));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    rx_valid = 0; rx_pop = 0; status_rd = 0; rx_err = 0;
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    rx_valid = 1; rx_data = d; rx_err = e; cyc();
  endtask

  task automatic pop(input bit rd);
    rx_pop = 1; status_rd = rd; cyc();
  endtask

  task automatic rdst();
    status_rd = 1; cyc();
  endtask

  task automatic drain();
    while (q.size() > 0) pop(1);
    rdst();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    stk = 0; temt_m = 1; thre_m = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 reset status", status, 8'h60);
    chk("R1 reset irqs", {ls_irq, err_irq, dma_req}, 0);

    // queue mode: bad characters buried behind good ones (R3, R7)
    fifo_mode = 1; ls_irq_en = 1; dma_en = 1;
    push(8'h11, 0); push(8'h12, 0); push(8'h13, 0);
    push(8'h14, 3'b001);
    push(8'h15, 0); push(8'h16, 3'b110);
    rdst(); rdst();                // R7 read leaves bit 7 up
    repeat (8) pop(0);
    rdst();

    // fill to full, overrun with concurrent read (R6, R5, R10)
    for (int i = 0; i < DEPTH; i++)
      push(8'(i + 8'h40), (i == 20 || i == DEPTH-1) ? 3'b010 : 3'b000);
    rx_valid = 1; rx_data = 8'hEE; status_rd = 1; cyc();
    push(8'hEF, 3'b100);
    rx_valid = 1; rx_data = 8'hF0; rx_pop = 1; cyc();   // full judged pre-pop
    dma_en = 0; idle_rd();
    for (int i = 0; i < DEPTH; i++) pop(i % 5 == 0);
    dma_en = 1;
    for (int i = 0; i < TRIG + 2; i++) push(8'(i), 0);  // R10 trigger
    drain();

    // single mode (R4)
    fifo_mode = 0;
    push(8'hA1, 3'b001); push(8'hA2, 0); rdst();
    pop(0); push(8'hA3, 3'b100); pop(1); push(8'hA4, 0);
    rx_valid = 1; rx_data = 8'hA5; rx_err = 3'b010; rx_pop = 1; cyc();
    drain();

    // transmit side (R11)
    tx_hold_empty = 0; cyc(); tx_shift_empty = 0; cyc();
    tx_hold_empty = 1; cyc(); tx_shift_empty = 1; cyc();

    // random phase in both modes
    for (int m = 0; m < 2; m++) begin
      fifo_mode = (m == 0);
      for (int i = 0; i < 4000; i++) begin
        rx_valid  = ($urandom % 3) != 0;
        rx_data   = 8'($urandom);
        rx_err    = (($urandom % 5) == 0) ? 3'($urandom) : 3'b000;
        rx_pop    = ($urandom % 8) < (i % 600 < 300 ? 2 : 5);
        status_rd = ($urandom % 4) == 0;
        dma_en    = ($urandom % 16) != 0 ? dma_en : ~dma_en;
        ls_irq_en = ($urandom % 16) != 0 ? ls_irq_en : ~ls_irq_en;
        tx_hold_empty  = 1'($urandom);
        tx_shift_empty = 1'($urandom);
        cyc();
      end
      drain();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic idle_rd();
    rdst(); cyc();
  endtask
endmodule